// File: doc/BRIEF.md
# ATA Host Interrupt Status and Mask Register

This block is the interrupt control word of a bus-master ATA host controller. It latches eight kinds of event (address error, reached-multiple, device timing error, UDMA terminate, timer, bus error, transfer end and the drive's own interrupt line) into sticky flags. It pairs each flag with a mask bit and drives one registered interrupt request toward the CPU. Software reads both bytes as one 16-bit word, clears flags by writing ones, and loads the mask byte through the high byte enable.

Two couplings reach outside the word itself. Acknowledging the interrupt bit of the DMA status register arrives as a one-cycle side-channel pulse. That pulse drops the transfer-end and host flags and zeroes the entire mask byte. A bus-error event starts a FIFO flush pulse that stays asserted for a parameterised number of clocks, twelve by default, so the data path is reset for at least the minimum time it needs.

Top module: `ata_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the flag byte and the mask byte read as zero, and both the interrupt request and the FIFO flush output are low.
- R2: A one-cycle pulse on event input n sets flag n, and the flag is readable from the next cycle on. The bit positions are: 7 address error, 6 reached multiple, 5 device timing, 4 UDMA terminate, 3 timer, 2 bus error, 1 transfer end, 0 host.
- R3: A register write with byte enable bit 0 set clears every flag whose write-data bit in 7:0 is 1 and leaves flags whose bit is 0 untouched. With byte enable bit 0 clear, the flags are not changed.
- R4: A register write with byte enable bit 1 set loads write-data bits 15:8 into the mask byte, and mask bit n+8 masks flag n. The read word is {mask byte, flag byte}.
- R5: The interrupt request is a register that, one clock after the flag and mask bytes hold a value, is high exactly when some flag is set and its mask bit is clear.
- R6: A pulse on the DMA-status acknowledge input clears flags 1 and 0, clears all eight mask bits, and leaves flags 7 to 2 unchanged.
- R7: When an event pulse and a clear (from a register write or the DMA acknowledge) reach the same flag in one cycle, the flag ends up set.
- R8: When the DMA acknowledge and a mask-byte write occur in the same cycle, the mask byte ends up zero.
- R9: A bus-error event (input bit 2) raises the FIFO flush output from the next cycle on, for FLUSH_CLKS consecutive cycles (12 by default). A further bus-error event during the flush restarts the full count. Other events do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag position |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables: bit 0 flag byte, bit 1 mask byte |
| reg_wdata | input | 16 | Write data: 15:8 mask, 7:0 write-one-to-clear |
| dma_intr_ack | input | 1 | Pulse when software writes 1 to the DMA status interrupt bit |
| reg_rdata | output | 16 | Current {mask byte, flag byte} |
| irq_o | output | 1 | Registered interrupt request |
| fifo_flush_o | output | 1 | FIFO reset, held for FLUSH_CLKS cycles after a bus error |

## Verification
The bench targets the cycles where two writers meet one bit. It covers an event and a clear on the same flag, where a design with the wrong priority loses an interrupt. It also covers the DMA acknowledge alongside a mask write, where the wrong priority leaves a stale mask. It checks that the acknowledge wipes the mask but spares the upper six flags; a design that clears too much drops error events, and one that clears too little keeps every later source masked. The flush pulse is measured in cycles, both for a single bus error and for a retrigger partway through, which catches an off-by-one count or a counter that ignores the second event.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;

    localparam int SRC_N = 8;
    localparam int WORD_W = 2 * SRC_N;
    localparam int DEF_FLUSH_CLKS = 12;

    // Flag positions within the low byte
    localparam int SRC_HOST      = 0;
    localparam int SRC_XFER_END  = 1;
    localparam int SRC_BUS_ERR   = 2;
    localparam int SRC_TIMER     = 3;
    localparam int SRC_UDMA_TERM = 4;
    localparam int SRC_DEV_TIME  = 5;
    localparam int SRC_MULT_HIT  = 6;
    localparam int SRC_ADDR_ERR  = 7;

    typedef struct packed {
        logic [SRC_N-1:0] mask;
        logic [SRC_N-1:0] flag;
    } irq_word_t;

    // Flags dropped by the DMA-status acknowledge
    function automatic logic [SRC_N-1:0] dma_ack_bits();
        logic [SRC_N-1:0] v;
        v = '0;
        v[SRC_HOST]     = 1'b1;
        v[SRC_XFER_END] = 1'b1;
        return v;
    endfunction

    function automatic logic any_pending(input irq_word_t w);
        return |(w.flag & ~w.mask);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (clr_i[i])
                q <= 1'b0;
        end

        assign flags_o[i] = q;

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_o[i]);

        assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]);

        assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            (!clr_i[i] && !set_i[i]) |=> $stable(flags_o[i]));
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         wipe_i,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst || wipe_i)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    assert_wipe_R8: assert property (@(posedge clk) disable iff (rst)
        wipe_i |=> (mask_o == '0));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wipe_i) |=> (mask_o == $past(wdata_i)));

endmodule

// File: rtl/flush_timer.sv
module flush_timer #(
    parameter int HOLD = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (trig_i)
            cnt_q <= HOLD_V;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // Checker: length of the current high run, saturating
    localparam int RUN_W = CNT_W + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!busy_o)
            run_q <= '0;
        else if (run_q != {RUN_W{1'b1}})
            run_q <= run_q + 1'b1;
    end

    assert_start_R9: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> busy_o);

    assert_min_len_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (run_q >= RUN_W'(HOLD)));

endmodule

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl
    import ata_irq_pkg::*;
#(
    parameter int FLUSH_CLKS = DEF_FLUSH_CLKS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_pulse,
    input  logic              reg_wr,
    input  logic [1:0]        reg_be,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              dma_intr_ack,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              fifo_flush_o
);

    irq_word_t        wr_w;
    irq_word_t        cur_w;
    logic [SRC_N-1:0] flags;
    logic [SRC_N-1:0] mask;
    logic [SRC_N-1:0] clr_vec;
    logic             mask_wr;
    logic             irq_q;

    assign wr_w    = irq_word_t'(reg_wdata);
    assign mask_wr = reg_wr && reg_be[1];

    always_comb begin
        clr_vec = '0;
        if (reg_wr && reg_be[0])
            clr_vec = clr_vec | wr_w.flag;
        if (dma_intr_ack)
            clr_vec = clr_vec | dma_ack_bits();
    end

    irq_flag_bank #(.W(SRC_N)) flags_i (
        .clk     (clk),
        .rst     (rst),
        .set_i   (evt_pulse),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    irq_mask_reg #(.W(SRC_N)) mask_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (mask_wr),
        .wdata_i (wr_w.mask),
        .wipe_i  (dma_intr_ack),
        .mask_o  (mask)
    );

    flush_timer #(.HOLD(FLUSH_CLKS)) flush_i (
        .clk    (clk),
        .rst    (rst),
        .trig_i (evt_pulse[SRC_BUS_ERR]),
        .busy_o (fifo_flush_o)
    );

    assign cur_w.flag = flags;
    assign cur_w.mask = mask;
    assign reg_rdata  = cur_w;

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= any_pending(cur_w);
    end

    assign irq_o = irq_q;

    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(|(flags & ~mask)));

    assert_irq_raise_R5: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ~mask)) |=> irq_o);

    assert_ack_spares_R6: assert property (@(posedge clk) disable iff (rst)
        (dma_intr_ack && !(reg_wr && reg_be[0]))
            |=> (flags[SRC_N-1:2] == $past(flags[SRC_N-1:2] | evt_pulse[SRC_N-1:2])));

endmodule

// File: tb/ata_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ata_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  evt_pulse;
    logic        reg_wr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata;
    logic        dma_intr_ack;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic        fifo_flush_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ata_irq_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .evt_pulse    (evt_pulse),
        .reg_wr       (reg_wr),
        .reg_be       (reg_be),
        .reg_wdata    (reg_wdata),
        .dma_intr_ack (dma_intr_ack),
        .reg_rdata    (reg_rdata),
        .irq_o        (irq_o),
        .fifo_flush_o (fifo_flush_o)
    );

    // {evt[43:36], wr[35], be[34:33], wdata[32:17], ack[16], expected read[15:0]}
    localparam int NV = 13;
    localparam logic [43:0] VEC [NV] = '{
        {8'h01, 1'b0, 2'b00, 16'h0000, 1'b0, 16'h0001},
        {8'h00, 1'b1, 2'b10, 16'hFA00, 1'b0, 16'hFA01},
        {8'h80, 1'b0, 2'b00, 16'h0000, 1'b0, 16'hFA81},
        {8'h00, 1'b1, 2'b01, 16'h0080, 1'b0, 16'hFA01},
        {8'h02, 1'b0, 2'b00, 16'h0000, 1'b0, 16'hFA03},
        {8'h00, 1'b0, 2'b00, 16'h0000, 1'b1, 16'h0000},
        {8'h44, 1'b0, 2'b00, 16'h0000, 1'b0, 16'h0044},
        {8'h00, 1'b1, 2'b00, 16'hFFFF, 1'b0, 16'h0044},
        {8'h04, 1'b1, 2'b11, 16'h0504, 1'b0, 16'h0544},
        {8'h00, 1'b1, 2'b01, 16'h00FF, 1'b0, 16'h0500},
        {8'h03, 1'b0, 2'b00, 16'h0000, 1'b1, 16'h0003},
        {8'h20, 1'b0, 2'b00, 16'h0000, 1'b0, 16'h0023},
        {8'h00, 1'b1, 2'b10, 16'hFF00, 1'b1, 16'h0020}
    };
    localparam string VTAG [NV] = '{
        "R2", "R4", "R2", "R3", "R2", "R6", "R2",
        "R3", "R7", "R3", "R7", "R2", "R8"
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_pulse    = '0;
        reg_wr       = 1'b0;
        reg_be       = '0;
        reg_wdata    = '0;
        dma_intr_ack = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] prev;
        int run;
        idle_inputs();
        rst = 1'b1;
        do_reset();

        // R1 reset state
        chk("R1 read word", 32'(reg_rdata), 32'h0000);
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 flush", 32'(fifo_flush_o), 32'h0);

        // Table walk: read word after each edge, irq from prior word (R5)
        prev = 16'h0000;
        for (int i = 0; i < NV; i++) begin
            evt_pulse    = VEC[i][43:36];
            reg_wr       = VEC[i][35];
            reg_be       = VEC[i][34:33];
            reg_wdata    = VEC[i][32:17];
            dma_intr_ack = VEC[i][16];
            @(posedge clk);
            #1;
            chk(VTAG[i], 32'(reg_rdata), 32'(VEC[i][15:0]));
            chk("R5 irq follows word", 32'(irq_o), 32'(|(prev[7:0] & ~prev[15:8])));
            prev = VEC[i][15:0];
            @(negedge clk);
            idle_inputs();
        end

        // R5 mask gating with the post-reset setup word
        do_reset();
        reg_wr = 1'b1; reg_be = 2'b11; reg_wdata = 16'hFAFF;
        @(negedge clk);
        idle_inputs();
        evt_pulse = 8'h80;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk("R5 masked source", 32'(irq_o), 32'h0);
        chk("R4 masked word", 32'(reg_rdata), 32'hFA80);
        evt_pulse = 8'h01;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
        chk("R5 unmasked host", 32'(irq_o), 32'h1);

        // R9 no flush for non-bus-error events
        do_reset();
        evt_pulse = 8'hFB;
        @(posedge clk);
        #1;
        idle_inputs();
        chk("R9 other events", 32'(fifo_flush_o), 32'h0);

        // R9 single bus error: flush run length
        do_reset();
        evt_pulse = 8'h04;
        @(posedge clk);
        #1;
        idle_inputs();
        chk("R2 bus error flag", 32'(reg_rdata[2]), 32'h1);
        run = 0;
        for (int k = 0; k < 40; k++) begin
            if (fifo_flush_o) run++;
            else break;
            @(posedge clk);
            #1;
        end
        chk("R9 flush length", 32'(run), 32'd12);

        // R9 retrigger after five high cycles
        do_reset();
        evt_pulse = 8'h04;
        @(posedge clk);
        #1;
        idle_inputs();
        run = 0;
        for (int k = 0; k < 40; k++) begin
            if (fifo_flush_o) run++;
            else break;
            evt_pulse = (k == 4) ? 8'h04 : 8'h00;
            @(posedge clk);
            #1;
        end
        idle_inputs();
        chk("R9 retrigger length", 32'(run), 32'd17);

        summary();
        $finish;
    end

endmodule